// File: doc/BRIEF.md
# Predicate Evaluation and Control Gating Unit

This combinational unit sits in the decode stage of an in-order five-stage pipeline in which every instruction names a predicate register. From the predicate register address and the predicate value (already forwarded from later stages), it works out whether the instruction may take effect. It then gates the decoder's register-write, memory-read and memory-write requests with that result. An instruction whose predicate is false still travels down the pipe, but as a harmless no-op, and it never flushes the fetch stage.

The unit also finds load-use hazards. If the instruction in the execute stage is a load and its destination matches any of the three decode-stage source addresses (first operand, second operand or predicate), the unit raises a stall. Fetch uses the stall to hold the PC and the fetch/decode register. While the stall is active, every gated enable and the kill output are forced low, so the slot entering execute becomes a bubble. A taken jump, with a PC-select code other than sequential and a true predicate, raises kill so that fetch discards the instruction fetched behind it.

Top module: `pred_gate_unit`

## Requirements
- R1: `exec_en` is 1 when `pred_addr` is nonzero and `pred_val` is nonzero, and 0 when `pred_addr` is nonzero and `pred_val` is zero.
- R2: When `pred_addr` is 0, `exec_en` is 1 whatever `pred_val` holds.
- R3: `reg_we` equals `dec_reg_we` AND `exec_en` AND NOT `stall`.
- R4: `mem_re` equals `dec_mem_re` AND `exec_en` AND NOT `stall`, and `mem_we` equals `dec_mem_we` AND `exec_en` AND NOT `stall`.
- R5: When `ex_is_load` is 1 and the nonzero `ex_dst` equals `src_a`, `src_b` or `pred_addr`, `stall` is 1.
- R6: A load whose `ex_dst` is register 0 never raises `stall`, because register 0 always reads as zero.
- R7: When `ex_is_load` is 0, `stall` is 0 whatever the addresses are.
- R8: `kill` is 1 exactly when `pc_sel` is not 2'b00 (the code for sequential fetch), `exec_en` is 1 and `stall` is 0.
- R9: When the predicate is false, `reg_we`, `mem_re`, `mem_we` and `kill` are all 0, whatever the decoder requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pred_addr | input | REG_AW | Predicate register address of the decode-stage instruction |
| pred_val | input | DATA_W | Forwarded value of the predicate register |
| src_a | input | REG_AW | First source register address in decode |
| src_b | input | REG_AW | Second source register address in decode |
| dec_reg_we | input | 1 | Register-write request from the decoder |
| dec_mem_re | input | 1 | Memory-read request from the decoder |
| dec_mem_we | input | 1 | Memory-write request from the decoder |
| ex_is_load | input | 1 | The instruction in execute is a load |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| pc_sel | input | PCSEL_W | Next-PC selection code from decode; 00 means sequential |
| exec_en | output | 1 | Predicate is true |
| reg_we | output | 1 | Gated register-write enable |
| mem_re | output | 1 | Gated memory-read enable |
| mem_we | output | 1 | Gated memory-write enable |
| stall | output | 1 | Load-use hazard: hold PC and fetch/decode, insert a bubble |
| kill | output | 1 | Discard the instruction fetched behind a taken jump |

## Verification
The bench builds the unit with 3-bit register addresses and a 4-bit data width. At that size it can cover every predicate address against every predicate value, combined with every decoder request and every PC-select code. It can also sweep every combination of execute destination and the three source addresses, with the load flag both set and clear. This covers the register-0 predicate, the register-0 load destination, a match on each source alone, and stall and kill arising together. All of these are compared against values the bench computes arithmetically.

// File: rtl/pgu_pkg.sv
// Package: shared types for the predicate evaluation and gating unit.
// Assumes a two-bit next-PC selection code in which zero means sequential.
package pgu_pkg;

    localparam int PCSEL_W = 2;

    // Next-PC selection codes; only the sequential code matters to gating.
    typedef enum logic [PCSEL_W-1:0] {
        PCS_SEQ = 2'b00,
        PCS_REL = 2'b01,
        PCS_REG = 2'b10
    } pc_sel_e;

    // Side-effect requests carried with an instruction.
    typedef struct packed {
        logic reg_we;
        logic mem_re;
        logic mem_we;
    } side_fx_t;

    localparam int NUM_SRC = 3;

endpackage

// File: rtl/pgu_pred_eval.sv
// Module: pgu_pred_eval
// Decides whether a decode-stage instruction may take effect. It assumes
// pred_val has already been forwarded, so an in-flight predicate write is seen.
// Register 0 used as the predicate means the instruction is unconditional.
module pgu_pred_eval #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] pred_addr,
    input  logic [DATA_W-1:0] pred_val,
    output logic              exec_en
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic uses_zero_reg;
    logic val_nonzero;

    // Detect the unconditional form and a true (nonzero) predicate value.
    always_comb begin
        uses_zero_reg = (pred_addr == ZERO_REG);
        val_nonzero   = |pred_val;
        exec_en       = uses_zero_reg | val_nonzero;
    end
endmodule

// File: rtl/pgu_hazard.sv
// Module: pgu_hazard
// Load-use hazard detector. It compares the execute-stage load destination
// with every decode-stage source, including the predicate address. Assumes
// register 0 is never really written, so a load into it never stalls.
module pgu_hazard #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 3
) (
    input  logic                           ex_is_load,
    input  logic [REG_AW-1:0]              ex_dst,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] srcs,
    output logic                           stall
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] hit;
    logic               dst_live;

    // Destination is a real register only when it is not register 0.
    always_comb dst_live = ex_is_load & (ex_dst != ZERO_REG);

    // One comparator per source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        always_comb hit[g] = dst_live & (srcs[g] == ex_dst);
    end

    // Any matching source holds the pipe.
    always_comb stall = |hit;
endmodule

// File: rtl/pgu_gate.sv
// Module: pgu_gate
// Masks the decoder's side-effect requests and the jump kill. Assumes exec_en
// and stall are settled in the same cycle; a stall suppresses everything so
// the slot entering execute becomes a bubble and a waiting jump is not taken.
module pgu_gate
    import pgu_pkg::*;
#(
    parameter int SEL_W = PCSEL_W
) (
    input  side_fx_t         req,
    input  logic             exec_en,
    input  logic             stall,
    input  logic [SEL_W-1:0] pc_sel,
    output side_fx_t         grant,
    output logic             kill
);
    logic allow;
    logic redirect;

    // An instruction proceeds only with a true predicate and no hazard.
    always_comb allow = exec_en & ~stall;

    // Any non-sequential selection redirects fetch.
    always_comb redirect = (pc_sel != SEL_W'(PCS_SEQ));

    // Gate each side-effect request individually.
    always_comb begin
        grant.reg_we = req.reg_we & allow;
        grant.mem_re = req.mem_re & allow;
        grant.mem_we = req.mem_we & allow;
    end

    // Flush the fetched instruction only for a jump that really goes.
    always_comb kill = redirect & allow;
endmodule

// File: rtl/pred_gate_unit.sv
// Module: pred_gate_unit (top)
// Decode-stage predicate evaluation, load-use stall detection and control
// gating. Purely combinational; assumes pred_val comes from the forwarding
// network and that fetch holds PC and fetch/decode while stall is high.
module pred_gate_unit
    import pgu_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0]  pred_addr,
    input  logic [DATA_W-1:0]  pred_val,
    input  logic [REG_AW-1:0]  src_a,
    input  logic [REG_AW-1:0]  src_b,
    input  logic               dec_reg_we,
    input  logic               dec_mem_re,
    input  logic               dec_mem_we,
    input  logic               ex_is_load,
    input  logic [REG_AW-1:0]  ex_dst,
    input  logic [PCSEL_W-1:0] pc_sel,
    output logic               exec_en,
    output logic               reg_we,
    output logic               mem_re,
    output logic               mem_we,
    output logic               stall,
    output logic               kill
);
    logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
    side_fx_t req;
    side_fx_t grant;

    // Collect the decode-stage sources and the decoder's requests.
    always_comb begin
        srcs[0]    = src_a;
        srcs[1]    = src_b;
        srcs[2]    = pred_addr;
        req.reg_we = dec_reg_we;
        req.mem_re = dec_mem_re;
        req.mem_we = dec_mem_we;
    end

    pgu_pred_eval #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_pred (
        .pred_addr (pred_addr),
        .pred_val  (pred_val),
        .exec_en   (exec_en)
    );

    pgu_hazard #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_haz (
        .ex_is_load (ex_is_load),
        .ex_dst     (ex_dst),
        .srcs       (srcs),
        .stall      (stall)
    );

    pgu_gate #(.SEL_W(PCSEL_W)) u_gate (
        .req     (req),
        .exec_en (exec_en),
        .stall   (stall),
        .pc_sel  (pc_sel),
        .grant   (grant),
        .kill    (kill)
    );

    // Present the gated enables on the ports.
    always_comb begin
        reg_we = grant.reg_we;
        mem_re = grant.mem_re;
        mem_we = grant.mem_we;
    end
endmodule

// File: rtl/pred_gate_unit_chk.sv
// Module: pred_gate_unit_chk
// Port-level property checker for pred_gate_unit, attached by bind. The unit
// has no clock, so the checks are immediate assertions on settled values.
module pred_gate_unit_chk
    import pgu_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_AW-1:0]  pred_addr,
    input logic [DATA_W-1:0]  pred_val,
    input logic               dec_reg_we,
    input logic               dec_mem_re,
    input logic               dec_mem_we,
    input logic               ex_is_load,
    input logic [REG_AW-1:0]  ex_dst,
    input logic [PCSEL_W-1:0] pc_sel,
    input logic               exec_en,
    input logic               reg_we,
    input logic               mem_re,
    input logic               mem_we,
    input logic               stall,
    input logic               kill
);
    // Check relations between inputs and outputs whenever anything changes.
    always_comb begin
        p_zero_pred_enables_r2: assert ((pred_addr != '0) || exec_en);
        p_zero_value_disables_r1: assert ((pred_addr == '0) || (pred_val != '0) || !exec_en);
        p_regwrite_needs_request_r3: assert (!reg_we || (dec_reg_we && exec_en && !stall));
        p_memory_needs_request_r4: assert ((!mem_re || dec_mem_re) && (!mem_we || dec_mem_we));
        p_no_load_no_stall_r7: assert (ex_is_load || !stall);
        p_zero_dst_no_stall_r6: assert ((ex_dst != '0) || !stall);
        p_kill_needs_jump_r8: assert (!kill || ((pc_sel != '0) && exec_en && !stall));
        p_false_pred_inert_r9: assert (exec_en || !(reg_we || mem_re || mem_we || kill));
    end
endmodule

bind pred_gate_unit pred_gate_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
    .pred_addr  (pred_addr),
    .pred_val   (pred_val),
    .dec_reg_we (dec_reg_we),
    .dec_mem_re (dec_mem_re),
    .dec_mem_we (dec_mem_we),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .pc_sel     (pc_sel),
    .exec_en    (exec_en),
    .reg_we     (reg_we),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .stall      (stall),
    .kill       (kill)
);

// File: tb/pred_gate_unit_test.sv
// Bench: pred_gate_unit_test
// Sweeps a small configuration (3-bit addresses, 4-bit data) of the unit
// and compares every output with values computed from the requirements.
module pred_gate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [AW-1:0] pred_addr, src_a, src_b, ex_dst;
    logic [DW-1:0] pred_val;
    logic dec_reg_we, dec_mem_re, dec_mem_we, ex_is_load;
    logic [1:0] pc_sel;
    logic exec_en, reg_we, mem_re, mem_we, stall, kill;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    pred_gate_unit #(.REG_AW(AW), .DATA_W(DW)) uut (
        .pred_addr (pred_addr), .pred_val (pred_val),
        .src_a (src_a), .src_b (src_b),
        .dec_reg_we (dec_reg_we), .dec_mem_re (dec_mem_re), .dec_mem_we (dec_mem_we),
        .ex_is_load (ex_is_load), .ex_dst (ex_dst), .pc_sel (pc_sel),
        .exec_en (exec_en), .reg_we (reg_we), .mem_re (mem_re), .mem_we (mem_we),
        .stall (stall), .kill (kill)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%b expected=%b (pa=%0d pv=%0d a=%0d b=%0d ld=%b dst=%0d sel=%0d)",
                     tag, act, exp, pred_addr, pred_val, src_a, src_b, ex_is_load, ex_dst, pc_sel);
        end
    endtask

    // Full comparison of all outputs against arithmetic expectations.
    task automatic check_all();
        logic e_en, e_st, ok;
        e_en = (pred_addr == 0) || (pred_val != 0);
        e_st = ex_is_load && (ex_dst != 0) &&
               ((ex_dst == src_a) || (ex_dst == src_b) || (ex_dst == pred_addr));
        ok = e_en && !e_st;
        chk((pred_addr == 0) ? "R2 exec_en" : "R1 exec_en", exec_en, e_en);
        chk((!ex_is_load) ? "R7 stall" : ((ex_dst == 0) ? "R6 stall" : "R5 stall"), stall, e_st);
        chk("R3 reg_we", reg_we, dec_reg_we && ok);
        chk("R4 mem_re", mem_re, dec_mem_re && ok);
        chk("R4 mem_we", mem_we, dec_mem_we && ok);
        chk("R8 kill", kill, (pc_sel != 2'b00) && ok);
        if (!e_en) chk("R9 inert", reg_we | mem_re | mem_we | kill, 1'b0);
    endtask

    initial begin
        pred_addr = '0; pred_val = '0; src_a = '0; src_b = '0; ex_dst = '0;
        dec_reg_we = 0; dec_mem_re = 0; dec_mem_we = 0; ex_is_load = 0; pc_sel = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: unconditional, no requests, sequential fetch.
        @(negedge clk);
        chk("R2 idle exec_en", exec_en, 1'b1);
        chk("R7 idle stall", stall, 1'b0);
        chk("R8 idle kill", kill, 1'b0);
        chk("R3 idle reg_we", reg_we, 1'b0);

        // Sweep predicate address, value, requests and PC-select; no hazard.
        for (int pa = 0; pa < (1 << AW); pa++)
            for (int pv = 0; pv < (1 << DW); pv++)
                for (int rq = 0; rq < 8; rq++)
                    for (int ps = 0; ps < 4; ps++) begin
                        @(posedge clk);
                        pred_addr = AW'(pa); pred_val = DW'(pv);
                        {dec_reg_we, dec_mem_re, dec_mem_we} = 3'(rq);
                        pc_sel = 2'(ps); ex_is_load = 1'b1; ex_dst = '0;
                        src_a = AW'(pa); src_b = AW'(pa);
                        @(negedge clk);
                        check_all();
                    end

        // Sweep hazard addresses with and without a load; true predicate.
        pred_val = 4'd1;
        {dec_reg_we, dec_mem_re, dec_mem_we} = 3'b111;
        for (int ld = 0; ld < 2; ld++)
            for (int d = 0; d < (1 << AW); d++)
                for (int a = 0; a < (1 << AW); a++)
                    for (int b = 0; b < (1 << AW); b++)
                        for (int p = 0; p < (1 << AW); p++) begin
                            @(posedge clk);
                            ex_is_load = 1'(ld); ex_dst = AW'(d);
                            src_a = AW'(a); src_b = AW'(b); pred_addr = AW'(p);
                            pc_sel = 2'((a + b) % 4);
                            @(negedge clk);
                            check_all();
                        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule